// File: doc/BRIEF.md
# Per-Line Edge Interrupt Unit

This block watches 24 already-synchronized input lines, arranged as three banks of eight. It latches a sticky flag for each line when that line shows an edge of a chosen direction. Each line has three settings, each held in a register bank of its own: an edge-direction bit, an arm bit and a latched flag bit. Software reaches all of these registers through a small flat register window, addressed by a 4-bit index with 8-bit data. A separate summary register has one bit per bank. The block drives a single active-high interrupt request whenever any flag is set.

An edge is found by comparing each line's level in the current cycle with its level one clock earlier. A flag is latched only on an armed line. It stays set until one of two things happens: software writes to the flag register of that bank, which clears the whole bank, or software disarms the line.

Top module: `eic_top`

## Requirements
- R1: After synchronous reset, every direction, arm and flag register reads 0x00, the summary reads 0x00 and `irq` is low.
- R2: The register index is {group[3:2], bank[1:0]}. Group 0 holds the direction registers, at indices 0 to 2. Group 1 holds the arm registers, at indices 4 to 6. Group 2 holds the flag registers, at indices 8 to 10. Index 12 is the summary. Every other index reads as 0x00, and `rd_data` is 0x00 whenever `rd_en` is low. Writes to the summary or to an unused index change nothing.
- R3: A direction bit of 1 makes its line flag on a 0-to-1 change, and a bit of 0 makes it flag on a 1-to-0 change. The change is seen by comparing the level sampled at a clock edge with the level sampled at the edge before. The flag reads 1 right after the clock edge that first samples the new level.
- R4: Edges on a line whose arm bit is 0 are never recorded. Writing 0 to an arm bit clears that line's flag at the same clock edge, even if an edge arrives in that cycle.
- R5: A write of any data value to a flag register clears all eight flags of that bank and leaves the other banks untouched.
- R6: If a qualifying edge on an armed line arrives in the same cycle as a clear write to its flag register, that line's flag reads 1 afterwards.
- R7: Summary bit n (n = 0 to 2) is 1 exactly when some flag in bank n is 1. Summary bits 7 to 3 read 0.
- R8: `irq` is a combinational active-high level equal to the OR of all 24 flags.
- R9: A set flag stays set while no clear write and no disarm touches it, whatever the line does afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_lvl | input | 24 | Synchronized line levels, bank b on bits 8b+7..8b |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_idx | input | 4 | Register index {group, bank} |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data, 0 when not reading |
| irq | output | 1 | Active-high interrupt request |

## Verification
The bench aims at the collisions between a clear and an edge. An edge that arrives in the cycle of a flag-register write must survive it; a design that clears last would lose that interrupt. An edge that arrives in the cycle of a disarm must not survive it; a design that sets last would raise an interrupt on a disabled line. The bench checks both edge directions on neighbouring lines, so a swapped direction flags the wrong line. It checks that flags stay set after the line returns to its old level, so a design that tracks the level instead of latching the edge would drop them. Writes to the summary and to unused indices must leave every register unchanged. A long random run with sparse line toggles and random register traffic compares every read and the `irq` level with a cycle model.

// File: rtl/eic_pkg.sv
package eic_pkg;
    localparam int BANK_W    = 8;
    localparam int NUM_BANKS = 3;
    localparam int IDX_W     = 4;

    typedef enum logic [1:0] {
        GRP_DIR = 2'd0,
        GRP_ARM = 2'd1,
        GRP_FLG = 2'd2,
        GRP_SUM = 2'd3
    } grp_e;

    typedef struct packed {
        logic        wr;
        logic        rd;
        grp_e        grp;
        logic [1:0]  bank;
        logic [BANK_W-1:0] data;
    } reg_acc_t;

    function automatic reg_acc_t decode_acc(input logic wr, input logic rd,
                                            input logic [IDX_W-1:0] idx,
                                            input logic [BANK_W-1:0] data);
        reg_acc_t a;
        a.wr   = wr;
        a.rd   = rd;
        a.grp  = grp_e'(idx[3:2]);
        a.bank = idx[1:0];
        a.data = data;
        return a;
    endfunction

    function automatic logic hits_bank(input reg_acc_t a, input grp_e g, input int b);
        return a.wr && (a.grp == g) && (a.bank == 2'(b));
    endfunction
endpackage

// File: rtl/eic_edge_detect.sv
module eic_edge_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] dir,
    output logic [W-1:0] hit
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    for (genvar i = 0; i < W; i++) begin : g_line
        assign hit[i] = dir[i] ? (lvl[i] & ~prev_q[i]) : (~lvl[i] & prev_q[i]);
    end
endmodule

// File: rtl/eic_bank.sv
module eic_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    input  logic         dir_wr,
    input  logic         arm_wr,
    input  logic         flg_wr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] arm_q,
    output logic [W-1:0] flg_q,
    output logic         any_flag
);
    logic [W-1:0] hit;
    logic [W-1:0] arm_next;
    logic [W-1:0] flg_next;

    eic_edge_detect #(.W(W)) u_edge (
        .clk (clk),
        .rst (rst),
        .lvl (lvl),
        .dir (dir_q),
        .hit (hit)
    );

    always_comb begin
        arm_next = arm_wr ? wr_data : arm_q;
        flg_next = ((flg_wr ? '0 : flg_q) | hit) & arm_next;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
            arm_q <= '0;
            flg_q <= '0;
        end else begin
            if (dir_wr) dir_q <= wr_data;
            arm_q <= arm_next;
            flg_q <= flg_next;
        end
    end

    assign any_flag = |flg_q;

    // R4
    disarmed_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (flg_q & ~arm_q) == '0);

    // R5
    bank_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (flg_wr && hit == '0) |=> flg_q == '0);

    // R9
    sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (!flg_wr && !arm_wr) |=> ($past(flg_q) & ~flg_q) == '0);

    // R3
    set_needs_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (flg_q & ~$past(flg_q) & ~$past(hit)) == '0);
endmodule

// File: rtl/eic_read_mux.sv
module eic_read_mux
    import eic_pkg::*;
#(
    parameter int BANKS = 3,
    parameter int W     = 8
) (
    input  reg_acc_t           acc,
    input  logic [BANKS*W-1:0] dir_all,
    input  logic [BANKS*W-1:0] arm_all,
    input  logic [BANKS*W-1:0] flg_all,
    input  logic [W-1:0]       summary,
    output logic [W-1:0]       rd_data
);
    always_comb begin
        rd_data = '0;
        if (acc.rd) begin
            unique case (acc.grp)
                GRP_DIR: if (int'(acc.bank) < BANKS) rd_data = dir_all[int'(acc.bank)*W +: W];
                GRP_ARM: if (int'(acc.bank) < BANKS) rd_data = arm_all[int'(acc.bank)*W +: W];
                GRP_FLG: if (int'(acc.bank) < BANKS) rd_data = flg_all[int'(acc.bank)*W +: W];
                GRP_SUM: if (acc.bank == 2'd0)       rd_data = summary;
                default: rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/eic_top.sv
module eic_top
    import eic_pkg::*;
#(
    parameter int BANKS = NUM_BANKS,
    parameter int W     = BANK_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [BANKS*W-1:0]   line_lvl,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [IDX_W-1:0]     reg_idx,
    input  logic [W-1:0]         wr_data,
    output logic [W-1:0]         rd_data,
    output logic                 irq
);
    localparam int LINES = BANKS * W;

    reg_acc_t         acc;
    logic [LINES-1:0] dir_all, arm_all, flg_all;
    logic [BANKS-1:0] bank_any;
    logic [W-1:0]     summary;

    assign acc = decode_acc(wr_en, rd_en, reg_idx, wr_data);

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        eic_bank #(.W(W)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .lvl      (line_lvl[b*W +: W]),
            .dir_wr   (hits_bank(acc, GRP_DIR, b)),
            .arm_wr   (hits_bank(acc, GRP_ARM, b)),
            .flg_wr   (hits_bank(acc, GRP_FLG, b)),
            .wr_data  (acc.data),
            .dir_q    (dir_all[b*W +: W]),
            .arm_q    (arm_all[b*W +: W]),
            .flg_q    (flg_all[b*W +: W]),
            .any_flag (bank_any[b])
        );
    end

    always_comb begin
        summary = '0;
        summary[BANKS-1:0] = bank_any;
    end

    assign irq = |flg_all;

    eic_read_mux #(.BANKS(BANKS), .W(W)) u_rd (
        .acc     (acc),
        .dir_all (dir_all),
        .arm_all (arm_all),
        .flg_all (flg_all),
        .summary (summary),
        .rd_data (rd_data)
    );

    // R8
    irq_summary_chk: assert property (@(posedge clk) disable iff (rst)
        irq == (summary != '0));

    // R7
    summary_upper_chk: assert property (@(posedge clk) disable iff (rst)
        summary[W-1:BANKS] == '0);

    // R2
    quiet_read_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> rd_data == '0);
endmodule

// File: tb/eic_top_tb.sv
module eic_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] line_lvl = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  reg_idx = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0]  m_dir [3];
    logic [7:0]  m_arm [3];
    logic [7:0]  m_flg [3];
    logic [23:0] m_prev;
    logic [7:0]  last_rd;

    eic_top u_dut (
        .clk(clk), .rst(rst), .line_lvl(line_lvl), .wr_en(wr_en), .rd_en(rd_en),
        .reg_idx(reg_idx), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_read(input logic [3:0] idx);
        logic [7:0] v = '0;
        case (idx[3:2])
            2'd0: if (idx[1:0] < 2'd3) v = m_dir[idx[1:0]];
            2'd1: if (idx[1:0] < 2'd3) v = m_arm[idx[1:0]];
            2'd2: if (idx[1:0] < 2'd3) v = m_flg[idx[1:0]];
            default: if (idx[1:0] == 2'd0) v = {5'b0, |m_flg[2], |m_flg[1], |m_flg[0]};
        endcase
        return v;
    endfunction

    function automatic string req_of(input logic [3:0] idx);
        if (idx[1:0] == 2'd3 || (idx[3:2] == 2'd3 && idx[1:0] != 2'd0)) return "R2";
        case (idx[3:2])
            2'd0: return "R3";
            2'd1: return "R4";
            2'd2: return "R9";
            default: return "R7";
        endcase
    endfunction

    task automatic m_reset();
        for (int b = 0; b < 3; b++) begin
            m_dir[b] = '0; m_arm[b] = '0; m_flg[b] = '0;
        end
        m_prev = '0;
    endtask

    task automatic m_clock(input logic wr, input logic [3:0] idx, input logic [7:0] d,
                           input logic [23:0] lvl);
        for (int b = 0; b < 3; b++) begin
            logic [7:0] cur  = lvl[b*8 +: 8];
            logic [7:0] old  = m_prev[b*8 +: 8];
            logic [7:0] edg  = (m_dir[b] & cur & ~old) | (~m_dir[b] & ~cur & old);
            logic [7:0] armn = (wr && idx == {2'd1, 2'(b)}) ? d : m_arm[b];
            logic [7:0] keep = (wr && idx == {2'd2, 2'(b)}) ? 8'h00 : m_flg[b];
            m_flg[b] = (keep | edg) & armn;
            m_arm[b] = armn;
            if (wr && idx == {2'd0, 2'(b)}) m_dir[b] = d;
        end
        m_prev = lvl;
    endtask

    // One cycle: drive after a falling edge, check before the rising edge.
    task automatic step(input logic wr, input logic rd, input logic [3:0] idx,
                        input logic [7:0] d, input logic [23:0] lvl);
        wr_en = wr; rd_en = rd; reg_idx = idx; wr_data = d; line_lvl = lvl;
        #1;
        last_rd = rd_data;
        if (rd) chk(req_of(idx), 32'(rd_data), 32'(m_read(idx)));
        else    chk("R2", 32'(rd_data), 32'h0);
        chk("R8", 32'(irq), 32'(|{m_flg[0], m_flg[1], m_flg[2]}));
        @(posedge clk);
        m_clock(wr, idx, d, lvl);
        @(negedge clk);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [23:0] lv;
        void'($urandom(32'd4242));
        m_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state of every index
        chk("R1", 32'(irq), 32'h0);
        for (int i = 0; i < 16; i++) begin
            step(1'b0, 1'b1, 4'(i), 8'h00, 24'h0);
            chk("R1", 32'(last_rd), 32'h0);
        end

        // R3: line 0 rising, line 1 falling
        step(1'b1, 1'b0, 4'd0, 8'h01, 24'h0);
        step(1'b1, 1'b0, 4'd4, 8'h03, 24'h0);
        step(1'b0, 1'b0, 4'd0, 8'h00, 24'h3);
        step(1'b0, 1'b1, 4'd8, 8'h00, 24'h3);
        chk("R3", 32'(last_rd), 32'h01);
        step(1'b0, 1'b0, 4'd0, 8'h00, 24'h0);
        step(1'b0, 1'b1, 4'd8, 8'h00, 24'h0);
        chk("R9", 32'(last_rd), 32'h03);
        step(1'b0, 1'b1, 4'd12, 8'h00, 24'h0);
        chk("R7", 32'(last_rd), 32'h01);

        // R5: any write clears the bank
        step(1'b1, 1'b0, 4'd8, 8'h5A, 24'h0);
        step(1'b0, 1'b1, 4'd8, 8'h00, 24'h0);
        chk("R5", 32'(last_rd), 32'h00);
        chk("R8", 32'(irq), 32'h0);

        // R6: edge in the same cycle as a clear
        step(1'b1, 1'b0, 4'd8, 8'hFF, 24'h1);
        step(1'b0, 1'b1, 4'd8, 8'h00, 24'h1);
        chk("R6", 32'(last_rd), 32'h01);

        // R4: disarm clears; edges on a disarmed line are not kept
        step(1'b1, 1'b0, 4'd4, 8'h02, 24'h1);
        step(1'b0, 1'b1, 4'd8, 8'h00, 24'h0);
        chk("R4", 32'(last_rd), 32'h00);
        step(1'b0, 1'b0, 4'd0, 8'h00, 24'h1);
        step(1'b0, 1'b1, 4'd8, 8'h00, 24'h1);
        chk("R4", 32'(last_rd), 32'h00);

        // R2: summary and unused indices ignore writes
        step(1'b1, 1'b0, 4'd12, 8'hFF, 24'h1);
        step(1'b1, 1'b0, 4'd3,  8'hFF, 24'h1);
        step(1'b1, 1'b0, 4'd15, 8'hFF, 24'h1);
        step(1'b0, 1'b1, 4'd12, 8'h00, 24'h1);
        chk("R2", 32'(last_rd), 32'h00);
        step(1'b0, 1'b1, 4'd3, 8'h00, 24'h1);
        chk("R2", 32'(last_rd), 32'h00);
        step(1'b0, 1'b1, 4'd0, 8'h00, 24'h1);
        chk("R2", 32'(last_rd), 32'h01);

        // Random traffic against the cycle model
        lv = 24'h1;
        for (int n = 0; n < 4000; n++) begin
            logic       w  = ($urandom % 6) == 0;
            logic       r  = !w && ($urandom % 2);
            logic [3:0] ix = 4'($urandom);
            logic [7:0] dv = 8'($urandom);
            lv = lv ^ (24'($urandom) & 24'($urandom) & 24'($urandom));
            step(w, r, ix, dv, lv);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule